// File: doc/BRIEF.md
# Transmit descriptor ring engine

This block feeds a serial transmitter from a circular table of transmit descriptors held in a 16-bit-wide synchronous memory. Each descriptor is four words long. After a poll strobe, the engine reads a descriptor's status word. If software has handed the descriptor over, the engine reads the byte count and the 32-bit buffer address. It then fetches the buffer one word at a time and offers the bytes to the transmitter over a ready/valid stream.

At the end of each buffer the engine does three things. It writes the status word back with the ownership bit cleared. It raises an event pulse if the descriptor asks for one. It then moves to the next descriptor, or back to the table base when the descriptor carries the wrap mark. It keeps walking the ring until it finds a descriptor that software still owns. It then waits on that same descriptor for the next poll.

The last buffer of a frame is flagged on the byte stream together with its final byte. That flag comes with a per-frame choice between appending a CRC and sending only a closing flag. A transmitter error cuts the current buffer short.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset the engine issues no memory read or write, offers no byte and raises no event until `poll` is seen high.
- R2: Descriptor layout in word addresses from the descriptor start: status at +0, byte count at +1, buffer address high half at +2, low half at +3. Status bits: 15 ready, 14 wrap, 13 event, 12 end of frame, 11 CRC select. The buffer address is a byte address, and its data word address is that value shifted right by one. The first descriptor fetched after reset sits at `ring_base`.
- R3: When the ready bit of a status word reads 0, the engine goes idle without transmitting. The next poll re-reads only that same status word.
- R4: Buffer words are read in rising address order. Each word gives its high byte first, then its low byte. Exactly count bytes are sent, so for an odd count the final low byte is dropped.
- R5: While `tx_valid` is high and `tx_ready` is low, the offered byte and its flags are held unchanged.
- R6: `tx_last` is high with the final byte of a buffer whose end-of-frame bit is 1, and never otherwise. With the end-of-frame bit at 0, the CRC select bit has no effect on the stream.
- R7: `tx_crc` equals the CRC select bit on the final byte of an end-of-frame buffer, and is 0 on every other byte.
- R8: Once a buffer is finished, the engine writes its status word back to the same address with bit 15 cleared and all other bits unchanged.
- R9: After a write-back, the next read targets `ring_base` if the wrap bit was 1, and the descriptor 4 words further on otherwise. This happens without waiting for a poll.
- R10: If the event bit is 1, `irq_txb` is high for exactly one cycle, in the write-back cycle. If the event bit is 0, `irq_txb` stays low.
- R11: When `tx_err` is high while a buffer is being fetched or sent, no further byte of it is handed over, including one offered in that same cycle. The status word is then written back as in R8, and the walk continues as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll | input | 1 | Request to (re)examine the current descriptor |
| ring_base | input | ADDR_W | Word address of the first descriptor of the ring |
| mem_rd | output | 1 | Memory read strobe, data returned next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after `mem_rd` |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_data | output | 8 | Offered byte |
| tx_last | output | 1 | Offered byte ends a frame |
| tx_crc | output | 1 | Frame ends with a CRC (1) or only a closing flag (0) |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| tx_err | input | 1 | Transmitter reports an error on the current buffer |
| irq_txb | output | 1 | One-cycle buffer-serviced event |

## Verification
The hardest case to reach from the ports is an error that lands exactly between two word fetches in the middle of a buffer. In that case the abort must win over a pending memory read, and the ring must still advance correctly. The stimulus counts accepted bytes on the stream under a stalling ready pattern. Once the second byte has gone, it raises `tx_err` on the next cycle, which is while the engine is fetching the next word. A second hard case is a poll that finds a descriptor already handed back after a wrap. That case is reached by letting the ring walk all the way round before polling again.

// File: rtl/txr_pkg.sv
package txr_pkg;
   // Descriptor geometry in 16-bit words
   localparam int unsigned DESC_WORDS = 4;
   localparam int unsigned OFS_STAT   = 0;
   localparam int unsigned OFS_LEN    = 1;
   localparam int unsigned OFS_PHI    = 2;
   localparam int unsigned OFS_PLO    = 3;

   // Status word bit positions (top bits of the word)
   localparam int unsigned BIT_RDY  = 15;
   localparam int unsigned BIT_WRAP = 14;
   localparam int unsigned BIT_INT  = 13;
   localparam int unsigned BIT_LAST = 12;
   localparam int unsigned BIT_CRC  = 11;

   typedef enum logic [2:0] {
      S_IDLE,
      S_REQ,
      S_CAP,
      S_DREQ,
      S_DCAP,
      S_SEND,
      S_DONE
   } eng_state_t;
endpackage

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr
   import txr_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              advance,
   input  logic              wrap,
   input  logic [ADDR_W-1:0] base_i,
   output logic [ADDR_W-1:0] cur_o
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_WORDS);

   logic              first_q;
   logic [ADDR_W-1:0] cur_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_q <= 1'b1;
         cur_q   <= '0;
      end else if (start && first_q) begin
         first_q <= 1'b0;
         cur_q   <= base_i;
      end else if (advance) begin
         cur_q <= wrap ? base_i : cur_q + STEP;
      end
   end

   assign cur_o = cur_q;
endmodule

// File: rtl/txr_byte_feed.sv
module txr_byte_feed #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [ADDR_W-1:0] word_addr_i,
   input  logic              wload,
   input  logic [15:0]       word_i,
   input  logic              take,
   output logic [7:0]        byte_o,
   output logic              lo_o,
   output logic              rem_one_o,
   output logic [ADDR_W-1:0] addr_o
);
   logic [LEN_W-1:0]  rem_q;
   logic [15:0]       word_q;
   logic              lo_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         word_q <= '0;
         lo_q   <= 1'b0;
         addr_q <= '0;
      end else if (load) begin
         rem_q  <= len_i;
         addr_q <= word_addr_i;
         lo_q   <= 1'b0;
      end else begin
         if (wload) begin
            word_q <= word_i;
            lo_q   <= 1'b0;
         end
         if (take) begin
            rem_q <= rem_q - LEN_W'(1);
            lo_q  <= ~lo_q;
            if (lo_q) addr_q <= addr_q + ADDR_W'(1);
         end
      end
   end

   assign byte_o    = lo_q ? word_q[7:0] : word_q[15:8];
   assign lo_o      = lo_q;
   assign rem_one_o = (rem_q == LEN_W'(1));
   assign addr_o    = addr_q;
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
   import txr_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              poll,
   input  logic [ADDR_W-1:0] ring_base,
   output logic              mem_rd,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [15:0]       mem_wdata,
   input  logic [15:0]       mem_rdata,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   output logic              tx_crc,
   input  logic              tx_ready,
   input  logic              tx_err,
   output logic              irq_txb
);
   localparam int unsigned     IDX_W    = $clog2(DESC_WORDS);
   localparam logic [IDX_W-1:0] IDX_STAT = IDX_W'(OFS_STAT);
   localparam logic [IDX_W-1:0] IDX_LEN  = IDX_W'(OFS_LEN);
   localparam logic [IDX_W-1:0] IDX_PHI  = IDX_W'(OFS_PHI);
   localparam logic [IDX_W-1:0] IDX_PLO  = IDX_W'(OFS_PLO);
   localparam logic [15:0]      RDY_MASK = 16'(1) << BIT_RDY;

   if (ADDR_W < 4 || ADDR_W > 30) begin : g_bad_addr_w
      $error("tx_ring_engine: ADDR_W must lie in 4..30");
   end
   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len_w
      $error("tx_ring_engine: LEN_W must lie in 1..16");
   end

   eng_state_t        state_q, state_d;
   logic [IDX_W-1:0]  idx_q;
   logic [15:0]       stat_q;
   logic [15:0]       phi_q;
   logic [LEN_W-1:0]  len_q;

   logic [ADDR_W-1:0] cur_addr;
   logic [ADDR_W-1:0] feed_addr;
   logic              feed_load, feed_wload, feed_take;
   logic              feed_lo, feed_rem_one;
   logic [7:0]        feed_byte;
   logic              start, advance;
   logic [31:0]       ptr_full;
   logic [ADDR_W-1:0] ptr_word;
   logic              unused_ptr_bits;

   assign start           = (state_q == S_IDLE) && poll;
   assign ptr_full        = {phi_q, mem_rdata};
   assign ptr_word        = ptr_full[ADDR_W:1];
   assign unused_ptr_bits = ^{ptr_full[31:ADDR_W+1], ptr_full[0]};

   txr_ring_ptr #(.ADDR_W(ADDR_W)) u_ring_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .advance (advance),
      .wrap    (stat_q[BIT_WRAP]),
      .base_i  (ring_base),
      .cur_o   (cur_addr)
   );

   txr_byte_feed #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_byte_feed (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (feed_load),
      .len_i       (len_q),
      .word_addr_i (ptr_word),
      .wload       (feed_wload),
      .word_i      (mem_rdata),
      .take        (feed_take),
      .byte_o      (feed_byte),
      .lo_o        (feed_lo),
      .rem_one_o   (feed_rem_one),
      .addr_o      (feed_addr)
   );

   always_comb begin
      state_d    = state_q;
      feed_load  = 1'b0;
      feed_wload = 1'b0;
      feed_take  = 1'b0;
      advance    = 1'b0;
      unique case (state_q)
         S_IDLE: if (poll) state_d = S_REQ;
         S_REQ:  state_d = S_CAP;
         S_CAP: begin
            if (idx_q == IDX_STAT && !mem_rdata[BIT_RDY]) begin
               state_d = S_IDLE;
            end else if (idx_q == IDX_PLO) begin
               feed_load = 1'b1;
               state_d   = (len_q == '0) ? S_DONE : S_DREQ;
            end else begin
               state_d = S_REQ;
            end
         end
         S_DREQ: state_d = tx_err ? S_DONE : S_DCAP;
         S_DCAP: begin
            if (tx_err) begin
               state_d = S_DONE;
            end else begin
               feed_wload = 1'b1;
               state_d    = S_SEND;
            end
         end
         S_SEND: begin
            if (tx_err) begin
               state_d = S_DONE;
            end else if (tx_ready) begin
               feed_take = 1'b1;
               if (feed_rem_one)  state_d = S_DONE;
               else if (feed_lo)  state_d = S_DREQ;
            end
         end
         S_DONE: begin
            advance = 1'b1;
            state_d = S_REQ;
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         idx_q   <= '0;
         stat_q  <= '0;
         phi_q   <= '0;
         len_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == S_CAP) begin
            if (idx_q == IDX_STAT) stat_q <= mem_rdata;
            if (idx_q == IDX_LEN)  len_q  <= mem_rdata[LEN_W-1:0];
            if (idx_q == IDX_PHI)  phi_q  <= mem_rdata;
            if (state_d == S_REQ)  idx_q  <= idx_q + IDX_W'(1);
            else                   idx_q  <= '0;
         end else if (state_q == S_DONE || state_q == S_IDLE) begin
            idx_q <= '0;
         end
      end
   end

   always_comb begin
      unique case (state_q)
         S_REQ:   mem_addr = cur_addr + ADDR_W'(idx_q);
         S_DREQ:  mem_addr = feed_addr;
         default: mem_addr = cur_addr;
      endcase
   end

   assign mem_rd    = (state_q == S_REQ) || (state_q == S_DREQ);
   assign mem_we    = (state_q == S_DONE);
   assign mem_wdata = stat_q & ~RDY_MASK;
   assign tx_valid  = (state_q == S_SEND);
   assign tx_data   = feed_byte;
   assign tx_last   = (state_q == S_SEND) && feed_rem_one && stat_q[BIT_LAST];
   assign tx_crc    = tx_last && stat_q[BIT_CRC];
   assign irq_txb   = (state_q == S_DONE) && stat_q[BIT_INT];
endmodule

// File: rtl/txr_checker.sv
module txr_checker
   import txr_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] ring_base,
   input logic              mem_rd,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [15:0]       mem_wdata,
   input logic              tx_valid,
   input logic [7:0]        tx_data,
   input logic              tx_last,
   input logic              tx_crc,
   input logic              tx_ready,
   input logic              tx_err,
   input logic              irq_txb
);
   // R5: offered byte held while stalled
   a_r5_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready && !tx_err |=>
         tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_crc));

   // R7: CRC select only appears on an end-of-frame byte
   a_r7_crc_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      tx_crc |-> tx_last && tx_valid);

   // R8: write-back always hands ownership back
   a_r8_wb_clears_rdy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !mem_wdata[BIT_RDY]);

   // R9: wrap returns to the table base
   a_r9_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we && mem_wdata[BIT_WRAP] |=> mem_rd && mem_addr == $past(ring_base));

   // R9: no wrap steps to the following descriptor
   a_r9_step_next: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we && !mem_wdata[BIT_WRAP] |=>
         mem_rd && mem_addr == $past(mem_addr) + ADDR_W'(DESC_WORDS));

   // R10: event is a single-cycle pulse tied to the write-back
   a_r10_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      irq_txb |=> !irq_txb);
   a_r10_irq_with_wb: assert property (@(posedge clk) disable iff (!rst_n)
      irq_txb |-> mem_we && mem_wdata[BIT_INT]);

   // R2: memory port never reads and writes together
   a_r2_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_we));
endmodule

bind tx_ring_engine txr_checker #(.ADDR_W(ADDR_W)) u_txr_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .ring_base (ring_base),
   .mem_rd    (mem_rd),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .tx_valid  (tx_valid),
   .tx_data   (tx_data),
   .tx_last   (tx_last),
   .tx_crc    (tx_crc),
   .tx_ready  (tx_ready),
   .tx_err    (tx_err),
   .irq_txb   (irq_txb)
);

// File: tb/test_tx_ring_engine.sv
module test_tx_ring_engine;
   localparam int AW   = 8;
   localparam int NROW = 4;
   localparam logic [AW-1:0] BASE = 8'h10;
   // flags per row: {ready, wrap, event, end-of-frame, crc}
   localparam logic [4:0] ROW_FLG [NROW] = '{5'b10101, 5'b10011, 5'b10110, 5'b11011};
   localparam int         ROW_LEN [NROW] = '{4, 3, 2, 1};

   logic          clk = 1'b0;
   logic          rst_n, poll, tx_ready, tx_err;
   logic [AW-1:0] ring_base;
   logic          mem_rd, mem_we, tx_valid, tx_last, tx_crc, irq_txb;
   logic [AW-1:0] mem_addr;
   logic [15:0]   mem_wdata, mem_rdata;
   logic [7:0]    tx_data;

   logic [15:0] mem [256];
   logic [9:0]  cap_b [64];
   logic [9:0]  exp_b [64];
   logic [AW-1:0] rd_log [32];
   int cap_n = 0, exp_n = 0, rd_n = 0, wb_n = 0, irq_n = 0, exp_irq = 0, cyc = 0;
   logic [AW-1:0] last_rd = '0;
   bit ready_mode = 1'b0;
   int total = 0, bad = 0;

   always #4 clk = ~clk;

   tx_ring_engine #(.ADDR_W(AW), .LEN_W(16)) i_tx_ring_engine (
      .clk(clk), .rst_n(rst_n), .poll(poll), .ring_base(ring_base),
      .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
      .tx_crc(tx_crc), .tx_ready(tx_ready), .tx_err(tx_err), .irq_txb(irq_txb)
   );

   // synchronous memory model, one cycle read latency
   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr];
   end

   // stream sink and observer
   initial begin
      tx_ready = 1'b0;
      forever begin
         @(negedge clk);
         cyc++;
         tx_ready = ready_mode ? (cyc % 3 != 0) : 1'b1;
         #1;
         if (rst_n) begin
            if (tx_valid && tx_ready && !tx_err) begin
               if (cap_n < 64) cap_b[cap_n] = {tx_crc, tx_last, tx_data};
               cap_n++;
            end
            if (mem_rd) begin
               if (rd_n < 32) rd_log[rd_n] = mem_addr;
               rd_n++;
               last_rd = mem_addr;
            end
            if (mem_we) wb_n++;
            if (irq_txb) irq_n++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   task automatic pulse_poll();
      @(negedge clk); poll = 1'b1;
      @(negedge clk); poll = 1'b0;
   endtask

   task automatic wait_wb(input int target);
      while (wb_n < target) @(posedge clk);
      repeat (12) @(posedge clk);
   endtask

   task automatic put_desc(input logic [AW-1:0] a, input logic [4:0] flg,
                           input int len, input int r);
      mem[a]        = {flg, 11'b0};
      mem[a + 8'd1] = 16'(len);
      mem[a + 8'd2] = 16'h0000;
      mem[a + 8'd3] = 16'((16'h40 + 16 * r) * 2);
      for (int k = 0; k < 8; k++)
         mem[8'(8'h40 + 16 * r + k)] = {8'(r * 16 + 2 * k), 8'(r * 16 + 2 * k + 1)};
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(1'b0, "WD", "watchdog expired", cyc, 0);
      finish_run();
   end

   initial begin
      int s, si, sr;
      rst_n = 1'b0; poll = 1'b0; tx_err = 1'b0; ring_base = BASE;
      for (int i = 0; i < 256; i++) mem[i] = 16'h0;

      // one loop over the vector table: load ring, build expected stream
      for (int r = 0; r < NROW; r++) begin
         put_desc(BASE + 8'(4 * r), ROW_FLG[r], ROW_LEN[r], r);
         exp_irq += int'(ROW_FLG[r][2]);
         for (int j = 0; j < ROW_LEN[r]; j++) begin
            logic l, c;
            l = ROW_FLG[r][1] && (j == ROW_LEN[r] - 1);
            c = l && ROW_FLG[r][0];
            exp_b[exp_n] = {c, l, 8'(r * 16 + j)};
            exp_n++;
         end
      end

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      // R1: quiet until polled
      chk(rd_n == 0,  "R1", "reads before poll", rd_n, 0);
      chk(wb_n == 0,  "R1", "writes before poll", wb_n, 0);
      chk(cap_n == 0, "R1", "bytes before poll", cap_n, 0);
      chk(irq_n == 0, "R1", "events before poll", irq_n, 0);

      ready_mode = 1'b1;
      pulse_poll();
      wait_wb(NROW);

      // R2: descriptor word order, then first data word
      for (int k = 0; k < 4; k++)
         chk(rd_log[k] == BASE + 8'(k), "R2", "descriptor read address",
             int'(rd_log[k]), int'(BASE) + k);
      chk(rd_log[4] == 8'h40, "R2", "first data word address", int'(rd_log[4]), 'h40);

      // R4 R5 R6 R7: stream content under backpressure
      chk(cap_n == exp_n, "R4", "byte count", cap_n, exp_n);
      for (int i = 0; i < exp_n; i++)
         chk(cap_b[i] == exp_b[i], "R4 R5 R6 R7", "byte{crc,last,data}",
             int'(cap_b[i]), int'(exp_b[i]));

      // R8: ownership handed back, other bits kept
      for (int r = 0; r < NROW; r++)
         chk(mem[BASE + 8'(4 * r)] == {ROW_FLG[r] & 5'b01111, 11'b0}, "R8",
             "status write-back", int'(mem[BASE + 8'(4 * r)]),
             int'({ROW_FLG[r] & 5'b01111, 11'b0}));
      chk(irq_n == exp_irq, "R10", "event pulses", irq_n, exp_irq);
      chk(last_rd == BASE, "R9", "wrap to base", int'(last_rd), int'(BASE));

      // R3: software-owned descriptor is re-polled, not skipped
      s = rd_n; sr = cap_n;
      pulse_poll();
      repeat (12) @(posedge clk);
      chk(rd_n == s + 1, "R3", "reads on re-poll", rd_n - s, 1);
      chk(last_rd == BASE, "R3", "re-poll address", int'(last_rd), int'(BASE));
      chk(cap_n == sr, "R3", "bytes on re-poll", cap_n - sr, 0);

      // R6 R7 R9: hand descriptor 0 back as a one-buffer frame with CRC
      mem[BASE]        = {5'b10011, 11'b0};
      mem[BASE + 8'd1] = 16'd2;
      s = cap_n;
      pulse_poll();
      wait_wb(NROW + 1);
      chk(cap_n == s + 2, "R4", "two-byte buffer", cap_n - s, 2);
      chk(cap_b[s] == 10'h000, "R6", "first byte flags", int'(cap_b[s]), 'h000);
      chk(cap_b[s + 1] == 10'h301, "R7", "final byte crc+last", int'(cap_b[s + 1]), 'h301);
      chk(mem[BASE] == 16'h1800, "R8", "status after resend", int'(mem[BASE]), 'h1800);
      chk(last_rd == BASE + 8'd4, "R9", "step to next descriptor",
          int'(last_rd), int'(BASE) + 4);

      // R11: error between word fetches aborts the buffer
      mem[BASE + 8'd4] = {5'b10110, 11'b0};
      mem[BASE + 8'd5] = 16'd8;
      s = cap_n; si = irq_n;
      pulse_poll();
      while (cap_n < s + 2) @(posedge clk);
      @(negedge clk); tx_err = 1'b1;
      @(negedge clk); tx_err = 1'b0;
      wait_wb(NROW + 2);
      chk(cap_n == s + 2, "R11", "bytes after abort", cap_n - s, 2);
      chk(mem[BASE + 8'd4] == 16'h3000, "R11", "status after abort",
          int'(mem[BASE + 8'd4]), 'h3000);
      chk(irq_n == si + 1, "R10", "event on aborted buffer", irq_n - si, 1);
      chk(last_rd == BASE + 8'd8, "R11", "advance after abort",
          int'(last_rd), int'(BASE) + 8);

      finish_run();
   end
endmodule